// File: doc/BRIEF.md
# Real-time clock tick prescaler and interrupt collector

This block turns a slow reference clock enable into a family of periodic ticks and gathers them, together with alarm and stopwatch event pulses from the external time-of-day counters, into one interrupt line. The reference can run at 32768 Hz, 32000 Hz or 38400 Hz. A phase accumulator produces a 512 Hz base tick whose long-run average is exact for all three rates. A binary divider chain then derives every power-of-two rate down to 1 Hz.

Each tick and event sets a bit in a 16-bit status register. Software clears a status bit by writing a one to it. A 16-bit enable register masks the status register, and the level interrupt output is high while any enabled status bit is set. A plain single-cycle register port reads and writes the control, status and enable registers. Reads are combinational.

Top module: `rtc_tick_irq`

## Requirements
- R1: After reset, the control, status and enable registers read 0 and `irq_o` is low.
- R2: The control register sits at byte offset 0x10. Bit 7 is the run enable and bits 6:5 are the reference select. A read returns exactly these three bits, and all other bits read 0.
- R3: Select code 0 means a 32768 Hz reference. The 512 Hz bit first sets on reference pulse 64, the 4 Hz bit on pulse 8192, the 2 Hz bit on pulse 16384 and the 1 Hz bit on pulse 32768, all counted from the start of the run.
- R4: Select code 1 means a 32000 Hz reference. The accumulator spaces the 512 Hz ticks so that tick n falls on pulse ceil(n*32000/512): the first on pulse 63 and the second on pulse 125. The 1 Hz bit first sets on pulse 32000.
- R5: Select code 2 means a 38400 Hz reference, with a 512 Hz tick every 75 pulses.
- R6: The reserved select code 3 behaves as code 0.
- R7: The status bit positions are: stopwatch event at bit 0, alarm event at bit 2, 1 Hz at bit 4 and 2 Hz at bit 7. The rates 4, 8, 16, 32, 64, 128, 256 and 512 Hz occupy bits 8 through 15 in that order. Every slower tick coincides with a tick of each faster rate.
- R8: The status register sits at byte offset 0x14. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R9: A status bit whose source fires in the same cycle as a clearing write to that bit stays set.
- R10: The enable register sits at byte offset 0x18, holds 16 read/write bits, and `irq_o` is high exactly when the bitwise AND of status and enable is non-zero.
- R11: While the run enable is 0, the prescaler is held cleared and no tick bit sets. After run is set again, counting restarts from zero.
- R12: Status bits 1, 3, 5 and 6 always read 0, and a read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_en_i | input | 1 | One-cycle pulse per reference clock period |
| alarm_evt_i | input | 1 | Alarm match pulse from the time counters |
| stopw_evt_i | input | 1 | Stopwatch expiry pulse from the time counters |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
Two things can land on one status bit in the same clock: a source event setting the bit and a software write clearing it. The bench provokes this by driving an alarm pulse in the same cycle as a status write that has bit 2 set and bit 0 set. It then reads the register back. The result is correct when bit 2 is still set, because the event wins over the clear, and bit 0 is clear, because it had no event in that cycle.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned BASE_HZ  = 512;
  localparam int unsigned DIV_BITS = $clog2(BASE_HZ);

  localparam int unsigned OFF_CTRL = 'h10;
  localparam int unsigned OFF_STAT = 'h14;
  localparam int unsigned OFF_IEN  = 'h18;

  localparam int unsigned CTRL_RUN = 7;
  localparam int unsigned CTRL_SEL = 5;

  localparam int unsigned ST_STOPW = 0;
  localparam int unsigned ST_ALARM = 2;
  localparam int unsigned ST_1HZ   = 4;
  localparam int unsigned ST_2HZ   = 7;
  localparam int unsigned ST_PER   = 8;

  typedef enum logic [1:0] {
    REF_32768 = 2'd0,
    REF_32000 = 2'd1,
    REF_38400 = 2'd2,
    REF_RSVD  = 2'd3
  } ref_sel_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_irq_pkg::*;
#(
  parameter int unsigned REF_A_HZ = 32768,
  parameter int unsigned REF_B_HZ = 32000,
  parameter int unsigned REF_C_HZ = 38400
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                ref_en_i,
  input  ref_sel_e            sel_i,
  output logic [DIV_BITS:0]   tick_o
);
  localparam int unsigned MAX_AB  = (REF_A_HZ > REF_B_HZ) ? REF_A_HZ : REF_B_HZ;
  localparam int unsigned MAX_REF = (MAX_AB > REF_C_HZ) ? MAX_AB : REF_C_HZ;
  localparam int unsigned ACC_W   = $clog2(2 * MAX_REF + BASE_HZ + 1);

  logic [ACC_W-1:0]    acc_q, sum, rate;
  logic [DIV_BITS-1:0] div_q;
  logic                base;

  always_comb begin
    unique case (sel_i)
      REF_32000: rate = ACC_W'(REF_B_HZ);
      REF_38400: rate = ACC_W'(REF_C_HZ);
      default:   rate = ACC_W'(REF_A_HZ);
    endcase
  end

  assign sum  = acc_q + ACC_W'(BASE_HZ);
  assign base = run_i & ref_en_i & (sum >= rate);

  // phase accumulator: exact long-run average for non-integer ratios
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (!run_i)   acc_q <= '0;
    else if (ref_en_i) acc_q <= base ? sum - rate : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else if (base)   div_q <= div_q + 1'b1;
  end

  // tick_o[k] runs at BASE_HZ >> k
  assign tick_o[0] = base;
  for (genvar k = 1; k <= DIV_BITS; k++) begin : g_div
    assign tick_o[k] = base & (&div_q[k-1:0]);
  end
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] ien_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] status_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & ien_i);
endmodule

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq
  import rtc_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned REF_A_HZ = 32768,
  parameter int unsigned REF_B_HZ = 32000,
  parameter int unsigned REF_C_HZ = 38400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_en_i,
  input  logic              alarm_evt_i,
  input  logic              stopw_evt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN);
  localparam int unsigned       N_PER  = REG_W - ST_PER;

  logic             run_q;
  ref_sel_e         sel_q;
  logic [REG_W-1:0] ien_q;
  logic [REG_W-1:0] status, set_vec, clr_vec;
  logic [DIV_BITS:0] tick;
  logic             ctrl_wr, stat_wr, ien_wr;

  assign ctrl_wr = reg_we_i && (reg_addr_i == A_CTRL);
  assign stat_wr = reg_we_i && (reg_addr_i == A_STAT);
  assign ien_wr  = reg_we_i && (reg_addr_i == A_IEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      sel_q <= REF_32768;
    end else if (ctrl_wr) begin
      run_q <= reg_wdata_i[CTRL_RUN];
      sel_q <= ref_sel_e'(reg_wdata_i[CTRL_SEL+:2]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (ien_wr) ien_q <= reg_wdata_i;
  end

  rtc_prescaler #(
    .REF_A_HZ(REF_A_HZ),
    .REF_B_HZ(REF_B_HZ),
    .REF_C_HZ(REF_C_HZ)
  ) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .ref_en_i(ref_en_i),
    .sel_i   (sel_q),
    .tick_o  (tick)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[ST_STOPW] = stopw_evt_i;
    set_vec[ST_ALARM] = alarm_evt_i;
    set_vec[ST_1HZ]   = tick[DIV_BITS];
    set_vec[ST_2HZ]   = tick[DIV_BITS-1];
    // bit ST_PER+m carries 4 Hz << m
    for (int m = 0; m < N_PER; m++) set_vec[ST_PER+m] = tick[N_PER-1-m];
  end

  assign clr_vec = stat_wr ? reg_wdata_i : '0;

  rtc_irq_status #(.W(REG_W)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .ien_i   (ien_q),
    .status_o(status),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_CTRL) begin
      reg_rdata_o[CTRL_RUN]     = run_q;
      reg_rdata_o[CTRL_SEL+:2]  = sel_q;
    end else if (reg_addr_i == A_STAT) begin
      reg_rdata_o = status;
    end else if (reg_addr_i == A_IEN) begin
      reg_rdata_o = ien_q;
    end
  end
endmodule

// File: rtl/rtc_tick_irq_chk.sv
module rtc_tick_irq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        stat_wr_i,
  input logic [15:0] wdata_i,
  input logic        alarm_evt_i,
  input logic        run_i,
  input logic [9:0]  tick_i,
  input logic [15:0] status_i,
  input logic [15:0] ien_i,
  input logic        irq_i
);
  // R11
  halted_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !$rose(status_i[15]));
  // R7
  slow_nests_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i[9] |-> (&tick_i[8:0]));
  // R7
  alarm_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_evt_i |=> status_i[2]);
  // R8
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && wdata_i[2] && !alarm_evt_i) |=> !status_i[2]);
  // R8
  zero_write_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && !wdata_i[0] && status_i[0]) |=> status_i[0]);
  // R9
  set_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && wdata_i[2] && alarm_evt_i) |=> status_i[2]);
  // R10
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == 16'h0) |-> !irq_i);
endmodule

bind rtc_tick_irq rtc_tick_irq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stat_wr_i  (stat_wr),
  .wdata_i    (reg_wdata_i),
  .alarm_evt_i(alarm_evt_i),
  .run_i      (run_q),
  .tick_i     (tick),
  .status_i   (status),
  .ien_i      (ien_q),
  .irq_i      (irq_o)
);

// File: tb/rtc_tick_irq_tb_top.sv
`timescale 1ns/1ps
module rtc_tick_irq_tb_top;
  localparam logic [5:0] A_CTRL = 6'h10;
  localparam logic [5:0] A_STAT = 6'h14;
  localparam logic [5:0] A_IEN  = 6'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0, alarm = 1'b0, stopw = 1'b0, we = 1'b0;
  logic [5:0]  addr = A_STAT;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          checks = 0, errors = 0, pulse_cnt = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rtc_tick_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_en_i(ref_en), .alarm_evt_i(alarm),
    .stopw_evt_i(stopw), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0; addr = A_STAT; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata; addr = A_STAT;
  endtask

  task automatic one_pulse();
    ref_en = 1'b1;
    @(posedge clk); @(negedge clk);
    ref_en = 1'b0;
    pulse_cnt++;
  endtask

  task automatic until_bit(input int b, input int limit);
    logic [15:0] s;
    int n = 0;
    do begin one_pulse(); rd(A_STAT, s); n++; end
    while (!s[b] && n < limit);
  endtask

  task automatic start_run(input logic [15:0] ctrl);
    wr(A_CTRL, 16'h0000);
    wr(A_STAT, 16'hFFFF);
    wr(A_CTRL, ctrl);
    pulse_cnt = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_STAT, d); check("R1 status", d, 0);
    rd(A_IEN, d);  check("R1 enable", d, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    wr(A_CTRL, 16'hFFFF); rd(A_CTRL, d); check("R2 ctrl readback", d, 16'h00E0);
    wr(A_CTRL, 16'h00A0); rd(A_CTRL, d); check("R2 ctrl readback", d, 16'h00A0);
    wr(A_CTRL, 16'h0000);
    rd(6'h00, d); check("R12 unmapped read", d, 0);
  endtask

  task automatic t_code0();
    logic [15:0] s;
    int f15 = 0, f14 = 0, f8 = 0, f7 = 0;
    start_run(16'h0080);
    do begin
      one_pulse(); rd(A_STAT, s);
      if (s[15] && f15 == 0) f15 = pulse_cnt;
      if (s[14] && f14 == 0) f14 = pulse_cnt;
      if (s[8]  && f8  == 0) f8  = pulse_cnt;
      if (s[7]  && f7  == 0) f7  = pulse_cnt;
    end while (!s[4] && pulse_cnt < 40000);
    check("R3 512Hz first", f15, 64);
    check("R7 256Hz first at bit14", f14, 128);
    check("R3 4Hz first at bit8", f8, 8192);
    check("R3 2Hz first at bit7", f7, 16384);
    check("R3 1Hz first at bit4", pulse_cnt, 32768);
    check("R12 unused status bits", s & 16'h006A, 0);
  endtask

  task automatic t_code1();
    logic [15:0] s;
    start_run(16'h00A0);
    until_bit(15, 200); check("R4 first 512Hz tick", pulse_cnt, 63);
    wr(A_STAT, 16'h8000);
    until_bit(15, 200); check("R4 second 512Hz tick", pulse_cnt, 125);
    until_bit(4, 40000); check("R4 1Hz", pulse_cnt, 32000);
    rd(A_STAT, s); check("R7 2Hz set with 1Hz", s[7], 1);
  endtask

  task automatic t_code2();
    start_run(16'h00C0);
    until_bit(15, 200); check("R5 first 512Hz tick", pulse_cnt, 75);
    wr(A_STAT, 16'h8000);
    until_bit(15, 200); check("R5 second 512Hz tick", pulse_cnt, 150);
  endtask

  task automatic t_code3();
    start_run(16'h00E0);
    until_bit(15, 200); check("R6 reserved code as 32768", pulse_cnt, 64);
  endtask

  task automatic t_halt();
    logic [15:0] s;
    start_run(16'h0080);
    repeat (40) one_pulse();
    wr(A_CTRL, 16'h0000);
    wr(A_STAT, 16'hFFFF);
    repeat (300) one_pulse();
    rd(A_STAT, s); check("R11 no ticks while halted", s, 0);
    wr(A_CTRL, 16'h0080);
    pulse_cnt = 0;
    until_bit(15, 200); check("R11 restart from zero", pulse_cnt, 64);
  endtask

  task automatic t_events();
    logic [15:0] s;
    wr(A_CTRL, 16'h0000);
    wr(A_STAT, 16'hFFFF);
    stopw = 1'b1; @(posedge clk); @(negedge clk); stopw = 1'b0;
    rd(A_STAT, s); check("R7 stopwatch bit0", s, 16'h0001);
    alarm = 1'b1; @(posedge clk); @(negedge clk); alarm = 1'b0;
    rd(A_STAT, s); check("R7 alarm bit2", s, 16'h0005);
    wr(A_STAT, 16'h0000); rd(A_STAT, s); check("R8 zero write keeps", s, 16'h0005);
    wr(A_STAT, 16'h0004); rd(A_STAT, s); check("R8 one clears", s, 16'h0001);
    alarm = 1'b1; we = 1'b1; addr = A_STAT; wdata = 16'h0005;
    @(posedge clk); @(negedge clk);
    alarm = 1'b0; we = 1'b0; wdata = '0;
    rd(A_STAT, s); check("R9 set beats clear", s, 16'h0004);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(A_IEN, 16'h0001); check("R10 masked", irq, 0);
    wr(A_IEN, 16'h0004); check("R10 enabled", irq, 1);
    rd(A_IEN, d); check("R10 enable readback", d, 16'h0004);
    wr(A_STAT, 16'h0004); check("R10 cleared", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_code0();
    t_code1();
    t_code2();
    t_code3();
    t_halt();
    t_events();
    t_irq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule